// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches the serial clock line of a system management bus and measures how long it stays low without interruption. Time is counted in ticks that a programmable prescaler derives from the free-running system clock. The limits are given in ticks, so the real-time bounds (25 ms of clock-low, 35 ms to be ready for a new START) are set by choosing the tick period. A simulation can use the same logic with a few clock cycles per tick.

When the clock line has stayed low for the full limit, the monitor raises a one-cycle timeout pulse. It then asks the bus controller to end the transfer with a STOP, and it holds that request until the controller acknowledges it. In the same cycle as the timeout it issues a one-cycle reset to the receive logic of the slave. It also drops a ready-for-start status. That status returns after a fixed recovery interval, or earlier if a STOP appears on the bus. In both cases it returns well inside the bound by which a new START must be accepted. The clock and data inputs are assumed to be already synchronized to the system clock.

Top module: `smb_lowto_mon`

## Requirements
- R1: After reset, timeout_o, stop_req_o and slv_rst_o are 0 and start_ready_o is 1.
- R2: A tick occurs once every presc_i+1 system clock cycles. timeout_o asserts in the cycle after the LOW_TICKS-th tick during which scl_i has stayed continuously low. With presc_i = 0 this is the LOW_TICKS-th cycle after scl_i falls.
- R3: Whenever scl_i is high, the low-time count clears. Low phases of LOW_TICKS-1 ticks separated by high phases never cause a timeout.
- R4: timeout_o is a single-cycle pulse. It fires at most once per low phase, however long scl_i then stays low.
- R5: stop_req_o rises in the cycle after timeout_o and stays high until a cycle in which stop_ack_i is 1. It reads 0 in the following cycle.
- R6: slv_rst_o is a single-cycle pulse in the same cycle as timeout_o.
- R7: start_ready_o is 0 from the timeout cycle onward. It returns to 1 after RECOV_TICKS further ticks; with presc_i = 0 it reads 1 exactly RECOV_TICKS+1 cycles after the timeout cycle.
- R8: During recovery, a STOP on the bus (sda_i rising while scl_i is high) returns start_ready_o to 1 in the cycle after the sample that shows the rise.
- R9: start_ready_o never stays 0 for more than READY_TICKS ticks.
- R10: stop_ack_i has no effect while no stop request is pending: stop_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| presc_i | input | PRESC_W | Tick period minus one, in system clock cycles |
| stop_ack_i | input | 1 | Bus controller has taken the stop request |
| timeout_o | output | 1 | One-cycle pulse when clock-low time reaches the limit |
| stop_req_o | output | 1 | Request to generate STOP, held until acknowledged |
| slv_rst_o | output | 1 | One-cycle reset to the slave receive logic |
| start_ready_o | output | 1 | Slave can accept a new START |

## Verification
A low counter that fails to clear, or a prescaler that drifts, shows up on the first long clock-low phase. timeout_o then appears earlier or later than the cycle the tick count predicts, or appears on a bus whose low phases are all just legal. A stuck expiry flag shows as repeated timeout pulses, or as none at all, within a few ticks. A wrong recovery state shows as start_ready_o returning at the wrong cycle after a timeout, or ignoring a STOP. A wrong request latch shows as stop_req_o not surviving, or not clearing, one cycle after the acknowledge.

// File: rtl/smb_lowto_pkg.sv
package smb_lowto_pkg;
  typedef enum logic {
    RC_IDLE    = 1'b0,
    RC_RECOVER = 1'b1
  } rc_state_e;
endpackage

// File: rtl/smb_tick_gen.sv
// Free-running prescaler: one tick every presc_i+1 cycles.
module smb_tick_gen #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    // >= so a lowered setting never makes the counter run to wrap-around
    tick_o = (cnt_q >= presc_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smb_low_timer.sv
// Counts ticks while SCL is low; flags a single expiry per low phase.
module smb_low_timer #(
  parameter int LOW_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic tick_i,
  output logic timeout_o
);
  localparam int CW = $clog2(LOW_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          pulse_q, pulse_d;
  logic          hit;

  always_comb begin
    hit     = !scl_i && tick_i && !exp_q && (cnt_q == CW'(LOW_TICKS - 1));
    cnt_d   = cnt_q;
    exp_d   = exp_q;
    pulse_d = hit;
    if (scl_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (tick_i && !exp_q) begin
      if (hit) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      exp_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      exp_q   <= exp_d;
      pulse_q <= pulse_d;
    end
  end

  assign timeout_o = pulse_q;
endmodule

// File: rtl/smb_recov_ctl.sv
// Stop request latch and post-timeout recovery window.
module smb_recov_ctl
  import smb_lowto_pkg::*;
#(
  parameter int RECOV_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tick_i,
  input  logic to_pulse_i,
  input  logic stop_ack_i,
  output logic stop_req_o,
  output logic ready_o
);
  localparam int RW = $clog2(RECOV_TICKS + 1);

  rc_state_e     st_q, st_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          req_q, req_d;
  logic          sda_q;
  logic          bus_stop;

  assign bus_stop = scl_i && sda_i && !sda_q;

  always_comb begin
    st_d   = st_q;
    rcnt_d = rcnt_q;
    unique case (st_q)
      RC_IDLE: begin
        if (to_pulse_i) begin
          st_d   = RC_RECOVER;
          rcnt_d = '0;
        end
      end
      RC_RECOVER: begin
        if (to_pulse_i) begin
          rcnt_d = '0;
        end else if (bus_stop) begin
          st_d = RC_IDLE;
        end else if (tick_i) begin
          if (rcnt_q == RW'(RECOV_TICKS - 1)) st_d = RC_IDLE;
          else                                rcnt_d = rcnt_q + 1'b1;
        end
      end
      default: st_d = RC_IDLE;
    endcase
    // a fresh timeout wins over an acknowledge in the same cycle
    req_d = to_pulse_i ? 1'b1 : (stop_ack_i ? 1'b0 : req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RC_IDLE;
      rcnt_q <= '0;
      req_q  <= 1'b0;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      rcnt_q <= rcnt_d;
      req_q  <= req_d;
      sda_q  <= sda_i;
    end
  end

  assign stop_req_o = req_q;
  assign ready_o    = (st_q == RC_IDLE) && !to_pulse_i;
endmodule

// File: rtl/smb_lowto_mon.sv
module smb_lowto_mon #(
  parameter int PRESC_W     = 16,
  parameter int LOW_TICKS   = 25,
  parameter int RECOV_TICKS = 10,
  parameter int READY_TICKS = 35
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               stop_ack_i,
  output logic               timeout_o,
  output logic               stop_req_o,
  output logic               slv_rst_o,
  output logic               start_ready_o
);
  logic tick_w;
  logic to_w;

  smb_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .presc_i (presc_i),
    .tick_o  (tick_w)
  );

  smb_low_timer #(.LOW_TICKS(LOW_TICKS)) u_low (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .tick_i    (tick_w),
    .timeout_o (to_w)
  );

  smb_recov_ctl #(.RECOV_TICKS(RECOV_TICKS)) u_recov (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .tick_i     (tick_w),
    .to_pulse_i (to_w),
    .stop_ack_i (stop_ack_i),
    .stop_req_o (stop_req_o),
    .ready_o    (start_ready_o)
  );

  assign timeout_o = to_w;
  assign slv_rst_o = to_w;
endmodule

// File: rtl/smb_lowto_chk.sv
module smb_lowto_chk #(
  parameter int READY_TICKS = 35
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic stop_ack_i,
  input logic tick_i,
  input logic timeout_o,
  input logic stop_req_o,
  input logic slv_rst_o,
  input logic start_ready_o
);
  localparam int BW = $clog2(READY_TICKS + 2);
  logic [BW-1:0] nrdy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   nrdy_cnt <= '0;
    else if (start_ready_o)                       nrdy_cnt <= '0;
    else if (tick_i && nrdy_cnt <= BW'(READY_TICKS)) nrdy_cnt <= nrdy_cnt + 1'b1;
  end

  // R2
  to_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !$past(scl_i));
  // R4
  to_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  // R5
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> stop_req_o);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_o && !stop_ack_i) |=> stop_req_o);
  // R5
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_o && stop_ack_i && !timeout_o) |=> !stop_req_o);
  // R6
  srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rst_o |=> !slv_rst_o);
  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !start_ready_o);
  // R9
  ready_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrdy_cnt <= BW'(READY_TICKS));
  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req_o && !timeout_o) |=> !stop_req_o);
endmodule

bind smb_lowto_mon smb_lowto_chk #(.READY_TICKS(READY_TICKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .stop_ack_i    (stop_ack_i),
  .tick_i        (tick_w),
  .timeout_o     (timeout_o),
  .stop_req_o    (stop_req_o),
  .slv_rst_o     (slv_rst_o),
  .start_ready_o (start_ready_o)
);

// File: tb/tb_smb_lowto_mon.sv
`timescale 1ns/1ps
module tb_smb_lowto_mon;
  localparam int PW = 8;
  localparam int L  = 10;
  localparam int RC = 6;
  localparam int RD = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda, ack;
  logic [PW-1:0] presc;
  logic to_o, req_o, srst_o, rdy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  smb_lowto_mon #(.PRESC_W(PW), .LOW_TICKS(L), .RECOV_TICKS(RC), .READY_TICKS(RD)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl),
    .sda_i         (sda),
    .presc_i       (presc),
    .stop_ack_i    (ack),
    .timeout_o     (to_o),
    .stop_req_o    (req_o),
    .slv_rst_o     (srst_o),
    .start_ready_o (rdy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_to(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (to_o) break;
    end
  endtask

  task automatic settle();
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rdy_o) break;
      @(negedge clk);
    end
    presc = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; ack = 1'b0; presc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(to_o == 1'b0,   "R1 timeout", to_o, 0);
    chk(req_o == 1'b0,  "R1 stop_req", req_o, 0);
    chk(srst_o == 1'b0, "R1 slv_rst", srst_o, 0);
    chk(rdy_o == 1'b1,  "R1 ready", rdy_o, 1);
  endtask

  task automatic t_basic();
    int n, extra, rdy_k;
    bit req_ok;
    sda = 1'b0;
    @(negedge clk);
    scl = 1'b0;
    wait_to(n);
    chk(n == L,         "R2 cycles to timeout", n, L);
    chk(srst_o == 1'b1, "R6 slave reset with timeout", srst_o, 1);
    chk(rdy_o == 1'b0,  "R7 ready dropped at timeout", rdy_o, 0);
    chk(req_o == 1'b0,  "R5 request not yet set", req_o, 0);
    @(negedge clk);
    chk(to_o == 1'b0,   "R4 pulse width", to_o, 0);
    chk(srst_o == 1'b0, "R6 slave reset width", srst_o, 0);
    chk(req_o == 1'b1,  "R5 request set", req_o, 1);
    extra = 0; rdy_k = -1; req_ok = 1'b1;
    for (int k = 2; k <= 3 * L; k++) begin
      @(negedge clk);
      if (to_o) extra++;
      if (!req_o) req_ok = 1'b0;
      if (rdy_o && rdy_k < 0) rdy_k = k;
    end
    chk(extra == 0,       "R4 single pulse per low phase", extra, 0);
    chk(req_ok,           "R5 request held", req_ok, 1);
    chk(rdy_k == RC + 1,  "R7 ready return cycle", rdy_k, RC + 1);
    chk(rdy_k >= 0 && rdy_k <= RD, "R9 ready within bound", rdy_k, RD);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    chk(req_o == 1'b0, "R5 request cleared by ack", req_o, 0);
    settle();
  endtask

  task automatic t_presc();
    int n;
    presc = PW'(3);
    repeat (2) @(negedge clk);
    scl = 1'b0;
    wait_to(n);
    chk(n >= (L - 1) * 4 + 1 && n <= L * 4, "R2 prescaled timeout window", n, L * 4);
    settle();
  endtask

  task automatic t_restart();
    int pulses = 0;
    for (int r = 0; r < 3; r++) begin
      scl = 1'b0;
      for (int i = 0; i < L - 1; i++) begin
        @(negedge clk);
        if (to_o) pulses++;
      end
      scl = 1'b1;
      repeat (2) begin
        @(negedge clk);
        if (to_o) pulses++;
      end
    end
    chk(pulses == 0,   "R3 no timeout on short lows", pulses, 0);
    chk(req_o == 1'b0, "R3 no request on short lows", req_o, 0);
    chk(rdy_o == 1'b1, "R3 ready kept", rdy_o, 1);
  endtask

  task automatic t_stop_early();
    int n;
    sda = 1'b0;
    @(negedge clk);
    scl = 1'b0;
    wait_to(n);
    @(negedge clk);
    scl = 1'b1;
    @(negedge clk);
    chk(rdy_o == 1'b0, "R8 still recovering before stop", rdy_o, 0);
    sda = 1'b1;
    @(negedge clk);
    chk(rdy_o == 1'b1, "R8 ready after bus stop", rdy_o, 1);
    settle();
  endtask

  task automatic t_ack_idle();
    bit ok = 1'b1;
    ack = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (req_o || to_o || !rdy_o) ok = 1'b0;
    end
    ack = 1'b0;
    @(negedge clk);
    chk(ok && req_o == 1'b0, "R10 idle ack no effect", req_o, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_presc();
    t_restart();
    t_stop_early();
    t_ack_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule